// File: doc/BRIEF.md
# Prefix-Qualified Opcode Decoder with Timing Matrix

This block turns an opcode byte into the control strobes of a small 8-bit CPU. A byte register captures the opcode while a load strobe is high during the fetch cycle, and it holds that byte for the whole instruction. A bank of decode terms compares the held byte against per-term bit masks. Each term is also gated by seven mode flags:

- index prefix, and its complement;
- running (not halted);
- arithmetic enable;
- base page (no CB/ED prefix);
- CB page;
- ED page.

Because of this gating, one byte can select different groups under different prefixes.

A timing matrix forms every control bit as an OR of products. Each product combines one decode term, one machine-cycle line and one clock-state line. An external sequencer drives these lines one-hot. The decode terms and the control vector are combinational from the held opcode, the flags and the current M/T lines.

Top module: `opdec_top`

Modifier vector order, used below: bit0 idx_on, bit1 idx_off, bit2 run, bit3 alu_sel, bit4 base_set, bit5 cb_on, bit6 ed_on.

## Requirements
- R1: A synchronous active-high reset clears the opcode register to 0x00. With base_set=1 and run=1, pla_term is then exactly 9'h001.
- R2: The opcode register takes op_in on a rising edge where ld_op=1 and otherwise keeps its value, whatever op_in does.
- R3: pla_term bits are defined as follows (x marks a don't-care opcode bit):
  - bit0: opcode 00000000 with base_set.
  - bit1: opcode 01110110 with base_set and idx_off.
  - bit2: 01xxxxxx with base_set and idx_off.
  - bit3: 00xxx110 with base_set and idx_off.
  - bit4: 10xxxxxx with base_set and alu_sel.
  - bit5: 11xxx110 with base_set and alu_sel.
  - bit6: 01xxxxxx with cb_on.
  - bit7: 101xx0xx with ed_on.
  - bit8: 01xxx110 with base_set and idx_on.
- R4: A term whose required flag is low stays inactive, whatever the opcode. For example, 0x47 raises bit2 under base_set but bit6 under cb_on.
- R5: When run=0, every pla_term bit except bit0 and bit1 is 0.
- R6: ctl bits are 0 pc_inc, 1 rd_src, 2 wr_dst, 3 alu_go, 4 flags_we, 5 acc_we, 6 mem_rd, 7 mem_wr, 8 imm_lat, 9 bit_test, 10 hl_inc, 11 de_inc, 12 bc_dec, 13 rep_chk, 14 idx_add, 15 halt_hold.
- R7: m_state bit k means M(k+1) and t_state bit k means T(k+1). A control is high only at the firings listed below, each written as term:M/T. Every other control is 0.
  - pc_inc: t0:M1T2; t3, t5 and t8:M2T1.
  - rd_src: t2:M1T3; t4:M1T4; t6:M2T4.
  - wr_dst: t2:M1T4; t3:M2T3; t8:M4T3.
  - alu_go: t4:M1T4; t4:M2T1; t5:M2T3.
  - flags_we: t4:M2T2; t5:M2T4; t6:M3T1.
  - acc_we: t4:M2T2; t5:M2T4.
  - mem_rd: t3, t5, t7 and t8:M2T2; t8:M4T2.
  - mem_wr: t7:M3T2.
  - imm_lat: t3 and t5:M2T3.
  - bit_test: t6:M2T4.
  - hl_inc and de_inc: t7:M3T3.
  - bc_dec: t7:M3T4.
  - rep_chk: t7:M4T1.
  - idx_add: t8:M3T1.
  - halt_hold: t1:M1T4.
- R8: With m_state or t_state all zero, ctl is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_op | input | 1 | Opcode load strobe |
| op_in | input | 8 | Opcode byte from the fetch path |
| idx_on | input | 1 | Index prefix active |
| idx_off | input | 1 | Complement of index prefix |
| run | input | 1 | CPU not halted |
| alu_sel | input | 1 | Arithmetic enable |
| base_set | input | 1 | Instruction has no CB/ED prefix |
| cb_on | input | 1 | CB prefix page active |
| ed_on | input | 1 | ED prefix page active |
| m_state | input | 6 | One-hot machine cycle |
| t_state | input | 6 | One-hot clock state |
| pla_term | output | 9 | Decode term lines |
| ctl | output | 16 | Control vector |

## Verification
The only registered result is the opcode byte. The bench drives ld_op and op_in after a falling edge and lets one rising edge load them. It then reads pla_term after the next falling edge. Flags and M/T lines are combinational paths, so the bench changes them between edges and samples 1 ns later, with no clock in between. The hold check moves op_in while ld_op is low across a full edge and looks again one falling edge later.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int OPW   = 8;
  localparam int NMOD  = 7;
  localparam int NTERM = 9;
  localparam int NCTL  = 16;
  localparam int NM    = 6;
  localparam int NT    = 6;
  localparam int NENT  = 33;

  localparam int MB_IDX  = 0;
  localparam int MB_IDXN = 1;
  localparam int MB_RUN  = 2;
  localparam int MB_ALU  = 3;
  localparam int MB_BASE = 4;
  localparam int MB_CB   = 5;
  localparam int MB_ED   = 6;

  // terms that keep working while halted
  localparam logic [NTERM-1:0] EXEMPT = 9'b0_0000_0011;

  typedef struct packed {
    logic [OPW-1:0]  opm;
    logic [OPW-1:0]  opv;
    logic [NMOD-1:0] modm;
    logic [NMOD-1:0] modv;
  } term_t;

  function automatic term_t term_def(input int i);
    term_t r;
    case (i)
      0:       r = '{opm: 8'hFF, opv: 8'h00, modm: 7'h10, modv: 7'h10};
      1:       r = '{opm: 8'hFF, opv: 8'h76, modm: 7'h12, modv: 7'h12};
      2:       r = '{opm: 8'hC0, opv: 8'h40, modm: 7'h12, modv: 7'h12};
      3:       r = '{opm: 8'hC7, opv: 8'h06, modm: 7'h12, modv: 7'h12};
      4:       r = '{opm: 8'hC0, opv: 8'h80, modm: 7'h18, modv: 7'h18};
      5:       r = '{opm: 8'hC7, opv: 8'hC6, modm: 7'h18, modv: 7'h18};
      6:       r = '{opm: 8'hC0, opv: 8'h40, modm: 7'h20, modv: 7'h20};
      7:       r = '{opm: 8'hE4, opv: 8'hA0, modm: 7'h40, modv: 7'h40};
      default: r = '{opm: 8'hC7, opv: 8'h46, modm: 7'h11, modv: 7'h11};
    endcase
    return r;
  endfunction

  // entry = {ctl[3:0], term[3:0], m[3:0], t[3:0]}, m and t counted from 1
  function automatic logic [15:0] tmx_entry(input int e);
    logic [15:0] r;
    case (e)
      0:  r = 16'h0012;  1:  r = 16'hF114;  2:  r = 16'h1213;  3:  r = 16'h2214;
      4:  r = 16'h0321;  5:  r = 16'h6322;  6:  r = 16'h8323;  7:  r = 16'h2323;
      8:  r = 16'h1414;  9:  r = 16'h3414;  10: r = 16'h3421;  11: r = 16'h4422;
      12: r = 16'h5422;  13: r = 16'h0521;  14: r = 16'h6522;  15: r = 16'h8523;
      16: r = 16'h3523;  17: r = 16'h4524;  18: r = 16'h5524;  19: r = 16'h1624;
      20: r = 16'h9624;  21: r = 16'h4631;  22: r = 16'h6722;  23: r = 16'h7732;
      24: r = 16'hA733;  25: r = 16'hB733;  26: r = 16'hC734;  27: r = 16'hD741;
      28: r = 16'h0821;  29: r = 16'h6822;  30: r = 16'hE831;  31: r = 16'h6842;
      default: r = 16'h2843;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/opdec_ir.sv
module opdec_ir #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/opdec_pla.sv
module opdec_pla
  import opdec_pkg::*;
#(
  parameter int N = NTERM
) (
  input  logic [OPW-1:0]  op,
  input  logic [NMOD-1:0] mods,
  output logic [N-1:0]    term
);
  for (genvar g = 0; g < N; g++) begin : g_term
    localparam term_t TD = term_def(g);
    logic op_ok, mod_ok, live;
    assign op_ok  = ((op & TD.opm) == TD.opv);
    assign mod_ok = ((mods & TD.modm) == TD.modv);
    assign live   = EXEMPT[g] | mods[MB_RUN];
    assign term[g] = op_ok & mod_ok & live;
  end
endmodule

// File: rtl/opdec_matrix.sv
module opdec_matrix
  import opdec_pkg::*;
#(
  parameter int NTRM = NTERM,
  parameter int NC   = NCTL,
  parameter int NE   = NENT
) (
  input  logic [NTRM-1:0] term,
  input  logic [NM-1:0]   m_oh,
  input  logic [NT-1:0]   t_oh,
  output logic [NC-1:0]   ctl
);
  logic [NE-1:0] ent_hit;

  for (genvar e = 0; e < NE; e++) begin : g_ent
    localparam logic [15:0] EN = tmx_entry(e);
    localparam int TI = int'(EN[11:8]);
    localparam int MI = int'(EN[7:4]) - 1;
    localparam int SI = int'(EN[3:0]) - 1;
    assign ent_hit[e] = term[TI] & m_oh[MI] & t_oh[SI];
  end

  for (genvar c = 0; c < NC; c++) begin : g_ctl
    logic [NE-1:0] pick;
    for (genvar e = 0; e < NE; e++) begin : g_sel
      localparam logic [15:0] EN = tmx_entry(e);
      if (int'(EN[15:12]) == c) begin : g_on
        assign pick[e] = ent_hit[e];
      end else begin : g_off
        assign pick[e] = 1'b0;
      end
    end
    assign ctl[c] = |pick;
  end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_op,
  input  logic [OPW-1:0]   op_in,
  input  logic             idx_on,
  input  logic             idx_off,
  input  logic             run,
  input  logic             alu_sel,
  input  logic             base_set,
  input  logic             cb_on,
  input  logic             ed_on,
  input  logic [NM-1:0]    m_state,
  input  logic [NT-1:0]    t_state,
  output logic [NTERM-1:0] pla_term,
  output logic [NCTL-1:0]  ctl
);
  logic [OPW-1:0]  ir_q;
  logic [NMOD-1:0] mods;

  assign mods = {ed_on, cb_on, base_set, alu_sel, run, idx_off, idx_on};

  opdec_ir #(.W(OPW), .RST_VAL('0)) u_ir (
    .clk(clk), .rst(rst), .ld(ld_op), .d(op_in), .q(ir_q)
  );

  opdec_pla #(.N(NTERM)) u_pla (
    .op(ir_q), .mods(mods), .term(pla_term)
  );

  opdec_matrix #(.NTRM(NTERM), .NC(NCTL), .NE(NENT)) u_mx (
    .term(pla_term), .m_oh(m_state), .t_oh(t_state), .ctl(ctl)
  );
endmodule

// File: rtl/opdec_chk.sv
module opdec_chk
  import opdec_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ld_op,
  input logic [OPW-1:0]   op_in,
  input logic             run,
  input logic             cb_on,
  input logic [NM-1:0]    m_state,
  input logic [NT-1:0]    t_state,
  input logic [OPW-1:0]   ir_q,
  input logic [NTERM-1:0] pla_term,
  input logic [NCTL-1:0]  ctl
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ir_q == '0);

  assert_load_take_R2: assert property (@(posedge clk) disable iff (rst)
    ld_op |=> ir_q == $past(op_in));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ld_op |=> $stable(ir_q));

  assert_cb_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !cb_on |-> !pla_term[6]);

  assert_halt_mask_R5: assert property (@(posedge clk) disable iff (rst)
    !run |-> (pla_term & ~EXEMPT) == '0);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (m_state == '0 || t_state == '0) |-> ctl == '0);
endmodule

bind opdec_top opdec_chk u_chk (
  .clk(clk), .rst(rst), .ld_op(ld_op), .op_in(op_in), .run(run),
  .cb_on(cb_on), .m_state(m_state), .t_state(t_state), .ir_q(ir_q),
  .pla_term(pla_term), .ctl(ctl)
);

// File: tb/sim_opdec_top.sv
module sim_opdec_top;
  logic clk = 1'b0, rst = 1'b1, ld_op = 1'b0;
  logic [7:0] op_in = 8'h00;
  logic [6:0] mods = 7'h1E;
  logic [5:0] m_state = '0, t_state = '0;
  logic [8:0] pla_term;
  logic [15:0] ctl;
  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  opdec_top u0 (
    .clk(clk), .rst(rst), .ld_op(ld_op), .op_in(op_in),
    .idx_on(mods[0]), .idx_off(mods[1]), .run(mods[2]), .alu_sel(mods[3]),
    .base_set(mods[4]), .cb_on(mods[5]), .ed_on(mods[6]),
    .m_state(m_state), .t_state(t_state), .pla_term(pla_term), .ctl(ctl)
  );

  function automatic logic [8:0] ref_terms(input logic [7:0] op, input logic [6:0] f);
    logic [8:0] r;
    logic idx = f[0], idxn = f[1], rn = f[2], alu = f[3], bs = f[4], cb = f[5], ed = f[6];
    r[0] = (op == 8'h00) && bs;
    r[1] = (op == 8'h76) && bs && idxn;
    r[2] = rn && op[7:6] == 2'b01 && bs && idxn;
    r[3] = rn && op[7:6] == 2'b00 && op[2:0] == 3'b110 && bs && idxn;
    r[4] = rn && op[7:6] == 2'b10 && bs && alu;
    r[5] = rn && op[7:6] == 2'b11 && op[2:0] == 3'b110 && bs && alu;
    r[6] = rn && op[7:6] == 2'b01 && cb;
    r[7] = rn && op[7:5] == 3'b101 && !op[2] && ed;
    r[8] = rn && op[7:6] == 2'b01 && op[2:0] == 3'b110 && bs && idx;
    return r;
  endfunction

  // expected controls by machine cycle mi and state ti (1-based, 0 = idle)
  function automatic logic [15:0] ref_ctl(input logic [8:0] t, input int mi, input int ti);
    logic [15:0] c = '0;
    case ({mi[3:0], ti[3:0]})
      8'h12: c[0] = t[0];
      8'h13: c[1] = t[2];
      8'h14: begin c[15] = t[1]; c[2] = t[2]; c[1] = t[4]; c[3] = t[4]; end
      8'h21: begin c[0] = t[3] | t[5] | t[8]; c[3] = t[4]; end
      8'h22: begin c[6] = t[3] | t[5] | t[7] | t[8]; c[4] = t[4]; c[5] = t[4]; end
      8'h23: begin c[8] = t[3] | t[5]; c[2] = t[3]; c[3] = t[5]; end
      8'h24: begin c[4] = t[5]; c[5] = t[5]; c[1] = t[6]; c[9] = t[6]; end
      8'h31: begin c[4] = t[6]; c[14] = t[8]; end
      8'h32: c[7] = t[7];
      8'h33: begin c[10] = t[7]; c[11] = t[7]; end
      8'h34: c[12] = t[7];
      8'h41: c[13] = t[7];
      8'h42: c[6] = t[8];
      8'h43: c[2] = t[8];
      default: c = '0;
    endcase
    return c;
  endfunction

  task automatic chk_terms(input logic [7:0] op, input string rq);
    logic [8:0] e = ref_terms(op, mods);
    checks++;
    if (pla_term !== e) begin
      errs++;
      $display("FAIL %s op=%02h mods=%02h terms got %03h exp %03h", rq, op, mods, pla_term, e);
    end
  endtask

  task automatic chk_ctl(input logic [7:0] op, input int mi, input int ti, input string rq);
    logic [15:0] e;
    m_state = (mi == 0) ? 6'd0 : 6'd1 << (mi - 1);
    t_state = (ti == 0) ? 6'd0 : 6'd1 << (ti - 1);
    #1;
    e = ref_ctl(ref_terms(op, mods), mi, ti);
    checks++;
    if (ctl !== e) begin
      errs++;
      $display("FAIL %s op=%02h mods=%02h M%0d T%0d ctl got %04h exp %04h",
               rq, op, mods, mi, ti, ctl, e);
    end
  endtask

  task automatic load(input logic [7:0] op);
    @(negedge clk);
    op_in = op; ld_op = 1'b1;
    @(negedge clk);
    ld_op = 1'b0;
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    logic [6:0] combos [6];
    combos[0] = 7'h1E; combos[1] = 7'h1D; combos[2] = 7'h26;
    combos[3] = 7'h46; combos[4] = 7'h16; combos[5] = 7'h1A;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1: reset leaves NOP only
    chk_terms(8'h00, "R1");
    checks++;
    if (pla_term !== 9'h001) begin
      errs++; $display("FAIL R1 terms got %03h exp 001", pla_term);
    end
    // R1 mid-run reset
    load(8'h47);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk_terms(8'h00, "R1");
    // R2: hold while op_in moves
    load(8'h80);
    op_in = 8'h47;
    @(negedge clk); @(negedge clk);
    chk_terms(8'h80, "R2");
    // R4: same byte, different pages
    load(8'h47);
    mods = 7'h1E; #1; chk_terms(8'h47, "R4");
    checks++; if (pla_term !== 9'h004) begin errs++; $display("FAIL R4 got %03h exp 004", pla_term); end
    mods = 7'h26; #1; chk_terms(8'h47, "R4");
    checks++; if (pla_term !== 9'h040) begin errs++; $display("FAIL R4 got %03h exp 040", pla_term); end
    // R5: halted keeps HALT term
    load(8'h76);
    mods = 7'h1A; #1; chk_terms(8'h76, "R5");
    checks++; if (pla_term !== 9'h002) begin errs++; $display("FAIL R5 got %03h exp 002", pla_term); end
    // R3, R6, R7, R8: full sweep per flag combination
    for (int k = 0; k < 6; k++) begin
      for (int op = 0; op < 256; op++) begin
        mods = combos[k];
        load(op[7:0]);
        chk_terms(op[7:0], "R3");
        for (int mi = 0; mi <= 6; mi++)
          for (int ti = 0; ti <= 6; ti++)
            chk_ctl(op[7:0], mi, ti, (mi == 0 || ti == 0) ? "R8" : "R7");
      end
    end
    // random mix: R4 R5 R6 R7
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] op = 8'($urandom);
      mods = 7'($urandom);
      load(op);
      chk_terms(op, "R4");
      chk_ctl(op, 1 + int'($urandom % 6), 1 + int'($urandom % 6), "R6");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule